// File: doc/BRIEF.md
# Tagged Floating-Point Register File

This block holds the small set of architectural floating-point registers that sit in front of several execution units in an out-of-order engine. Every register is a two-state slot: READY, where it holds a usable value, or PENDING, where it waits for a result. A PENDING slot keeps a tag naming the unit that will produce its next value. Two combinational read ports serve instruction issue. Each port returns the busy flag, the tag and the stored value of the register it names. A consumer takes the value when the flag is clear and the tag when it is set.

Issuing an instruction moves its destination slot to PENDING and loads the tag of the unit chosen to execute it. The block snoops the result bus every cycle. Every PENDING slot whose tag equals the broadcast tag captures the broadcast data and returns to READY, and any number of slots may do so in the same cycle. A slot that has since been retagged by a later writer ignores the older producer's broadcast. A register-to-register move needs no execution unit. From a busy source it copies only the tag, so the destination waits on the same producer. From a ready source it copies the value. Decode and result-bus arbitration are outside this block.

Slot transitions, with their names:
- ISSUE: READY or PENDING to PENDING, on an issue or a tag move to the slot.
- MOVE_VAL: READY or PENDING to READY, on a value move into the slot.
- CAPTURE: PENDING to READY, on a broadcast whose tag matches the slot.
- HOLD: the slot keeps its state.

Top module: `tagged_regfile`

## Requirements
- R1: After reset, every register reads as not busy, with tag 0 and value 0.
- R2: A read of a READY register returns busy = 0 and the stored value, in the same cycle.
- R3: A read of a PENDING register returns busy = 1 and the tag it waits on, in the same cycle.
- R4: An issue with destination register index d (binary 0..NUM_REGS-1) and tag t makes d read busy with tag t from the next cycle on. The stored value of d is unchanged.
- R5: On a valid broadcast, every PENDING register whose tag equals the broadcast tag reads not busy with the broadcast data from the next cycle on. This may happen to several registers in one cycle.
- R6: A broadcast leaves unchanged any PENDING register whose tag differs from the broadcast tag. It also leaves every READY register unchanged.
- R7: When an issue targets a register in the same cycle as a broadcast that matches that register, the issue wins. The register reads busy with the new tag, and its value is not replaced.
- R8: In the cycle of a valid broadcast, a read of a PENDING register whose tag matches the broadcast returns busy = 0 and the broadcast data.
- R9: A move from a source that is busy after bypass makes the destination read busy with the source's tag from the next cycle on. A later matching broadcast fills both registers.
- R10: A move from a source that is not busy after bypass makes the destination read not busy with the source's value from the next cycle on. The bypassed broadcast data counts as the source's value.
- R11: When an issue and a move are requested in the same cycle, the move is ignored and the issue takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | IDX_W | Read port A register index |
| rd_a_busy | output | 1 | Port A: register is waiting on a producer |
| rd_a_tag | output | TAG_W | Port A: stored producer tag |
| rd_a_data | output | DATA_W | Port A: value, or broadcast data when bypassed |
| rd_b_idx | input | IDX_W | Read port B register index |
| rd_b_busy | output | 1 | Port B: register is waiting on a producer |
| rd_b_tag | output | TAG_W | Port B: stored producer tag |
| rd_b_data | output | DATA_W | Port B: value, or broadcast data when bypassed |
| iss_valid | input | 1 | Issue request |
| iss_dst | input | IDX_W | Issue destination register |
| iss_tag | input | TAG_W | Tag of the unit chosen for the issue |
| mv_valid | input | 1 | Register-to-register move request |
| mv_src | input | IDX_W | Move source register |
| mv_dst | input | IDX_W | Move destination register |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcasting producer |
| bc_data | input | DATA_W | Broadcast result data |

## Verification
The bench builds the block with four registers, 4-bit tags and 16-bit data. It draws tags from only six values, so matching broadcasts, stale broadcasts after a retag and several registers waiting on one tag all occur often. Directed sequences cover the collisions: an issue together with a matching broadcast, a move from a register whose producer is broadcasting in that cycle, and an issue together with a move.

// File: rtl/trfile_pkg.sv
package trfile_pkg;
    typedef enum logic {
        SLOT_READY   = 1'b0,
        SLOT_PENDING = 1'b1
    } slot_state_e;
endpackage

// File: rtl/trf_slot.sv
module trf_slot
    import trfile_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_tag_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_val_en,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              snoop_hit,
    input  logic [DATA_W-1:0] snoop_data,
    output logic              busy,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] value
);
    slot_state_e       state_q, state_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] val_q, val_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_READY;
            tag_q   <= '0;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
            val_q   <= val_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        val_d   = val_q;
        unique case (state_q)
            SLOT_READY: begin
                if (wr_tag_en) begin          // ISSUE
                    state_d = SLOT_PENDING;
                    tag_d   = wr_tag;
                end else if (wr_val_en) begin // MOVE_VAL
                    val_d   = wr_val;
                end
            end
            SLOT_PENDING: begin
                if (wr_tag_en) begin          // ISSUE (retag)
                    tag_d   = wr_tag;
                end else if (wr_val_en) begin // MOVE_VAL
                    state_d = SLOT_READY;
                    val_d   = wr_val;
                end else if (snoop_hit) begin // CAPTURE
                    state_d = SLOT_READY;
                    val_d   = snoop_data;
                end
            end
            default: state_d = SLOT_READY;
        endcase
    end

    always_comb begin
        busy  = (state_q == SLOT_PENDING);
        tag   = tag_q;
        value = val_q;
    end

    // R4: an issue leaves the slot pending on the new tag with its value kept
    a_r4_issue_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tag_en |=> busy && tag == $past(wr_tag) && value == $past(value));

    // R5: a matching broadcast completes a pending slot
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && snoop_hit && !wr_tag_en && !wr_val_en) |=> !busy && value == $past(snoop_data));

    // R10: a value move leaves the slot ready with the moved value
    a_r10_move_value: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_val_en && !wr_tag_en) |=> !busy && value == $past(wr_val));

    // R6: an idle ready slot keeps its value
    a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_tag_en && !wr_val_en) |=> !busy && $stable(value));
endmodule

// File: rtl/trf_rdport.sv
module trf_rdport #(
    parameter int NUM_REGS = 4,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 64,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_REGS-1:0]             eff_busy,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]  tags,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] eff_data,
    input  logic [IDX_W-1:0]                idx,
    output logic                            busy,
    output logic [TAG_W-1:0]                tag,
    output logic [DATA_W-1:0]               data
);
    always_comb begin
        busy = 1'b0;
        tag  = '0;
        data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                busy = eff_busy[i];
                tag  = tags[i];
                data = eff_data[i];
            end
        end
    end
endmodule

// File: rtl/tagged_regfile.sv
module tagged_regfile #(
    parameter int NUM_REGS = 4,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 64,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic              rd_a_busy,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic              rd_b_busy,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              mv_valid,
    input  logic [IDX_W-1:0]  mv_src,
    input  logic [IDX_W-1:0]  mv_dst,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data
);
    logic [NUM_REGS-1:0]             slot_busy, hit, eff_busy;
    logic [NUM_REGS-1:0]             wr_tag_en, wr_val_en;
    logic [NUM_REGS-1:0][TAG_W-1:0]  slot_tag;
    logic [NUM_REGS-1:0][DATA_W-1:0] slot_val, eff_data;

    logic              mv_go, mv_src_busy;
    logic [TAG_W-1:0]  mv_src_tag, new_tag;
    logic [DATA_W-1:0] mv_src_data;

    // R11: an issue pre-empts a move in the same cycle
    assign mv_go   = mv_valid && !iss_valid;
    assign new_tag = iss_valid ? iss_tag : mv_src_tag;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        // R8: result bypass onto the effective view
        assign hit[i]      = slot_busy[i] && bc_valid && (slot_tag[i] == bc_tag);
        assign eff_busy[i] = slot_busy[i] && !hit[i];
        assign eff_data[i] = hit[i] ? bc_data : slot_val[i];

        assign wr_tag_en[i] = (iss_valid && iss_dst == IDX_W'(i)) ||
                              (mv_go && mv_src_busy && mv_dst == IDX_W'(i));
        assign wr_val_en[i] = mv_go && !mv_src_busy && mv_dst == IDX_W'(i);

        trf_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_tag_en  (wr_tag_en[i]),
            .wr_tag     (new_tag),
            .wr_val_en  (wr_val_en[i]),
            .wr_val     (mv_src_data),
            .snoop_hit  (hit[i]),
            .snoop_data (bc_data),
            .busy       (slot_busy[i]),
            .tag        (slot_tag[i]),
            .value      (slot_val[i])
        );

        // R6: a stale broadcast leaves a pending slot untouched
        a_r6_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_busy[i] && bc_valid && slot_tag[i] != bc_tag && !wr_tag_en[i] && !wr_val_en[i])
            |=> slot_busy[i] && $stable(slot_tag[i]) && $stable(slot_val[i]));

        // R11: a register addressed only by a suppressed move is unchanged
        a_r11_move_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && mv_valid && mv_dst == IDX_W'(i) && iss_dst != IDX_W'(i) && !hit[i])
            |=> $stable(slot_busy[i]) && $stable(slot_tag[i]) && $stable(slot_val[i]));
    end

    trf_rdport #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_a (
        .eff_busy (eff_busy), .tags (slot_tag), .eff_data (eff_data), .idx (rd_a_idx),
        .busy (rd_a_busy), .tag (rd_a_tag), .data (rd_a_data)
    );

    trf_rdport #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_b (
        .eff_busy (eff_busy), .tags (slot_tag), .eff_data (eff_data), .idx (rd_b_idx),
        .busy (rd_b_busy), .tag (rd_b_tag), .data (rd_b_data)
    );

    trf_rdport #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_mv (
        .eff_busy (eff_busy), .tags (slot_tag), .eff_data (eff_data), .idx (mv_src),
        .busy (mv_src_busy), .tag (mv_src_tag), .data (mv_src_data)
    );

    // R9: a move from a busy source copies its tag
    a_r9_move_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_go && mv_src_busy) |=> slot_busy[$past(mv_dst)] && slot_tag[$past(mv_dst)] == $past(mv_src_tag));
endmodule

// File: tb/sim_tagged_regfile.sv
module sim_tagged_regfile;
    localparam int NR = 4;
    localparam int TW = 4;
    localparam int DW = 16;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0, iss_dst = '0, mv_src = '0, mv_dst = '0;
    logic rd_a_busy, rd_b_busy;
    logic [TW-1:0] rd_a_tag, rd_b_tag;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic iss_valid = 1'b0, mv_valid = 1'b0, bc_valid = 1'b0;
    logic [TW-1:0] iss_tag = '0, bc_tag = '0;
    logic [DW-1:0] bc_data = '0;

    int checks = 0;
    int errors = 0;

    logic          m_busy [NR];
    logic [TW-1:0] m_tag  [NR];
    logic [DW-1:0] m_val  [NR];

    always #5 clk = ~clk;

    tagged_regfile #(.NUM_REGS(NR), .TAG_W(TW), .DATA_W(DW)) u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_hit(input int i);
        return m_busy[i] && bc_valid && m_tag[i] == bc_tag;
    endfunction

    function automatic bit m_eff_busy(input int i);
        return m_busy[i] && !m_hit(i);
    endfunction

    function automatic logic [DW-1:0] m_eff_data(input int i);
        return m_hit(i) ? bc_data : m_val[i];
    endfunction

    task automatic check_port(input int idx, input logic b, input logic [TW-1:0] t,
                              input logic [DW-1:0] d, input string req);
        chk(b == m_eff_busy(idx), {req, " busy"}, 32'(b), 32'(m_eff_busy(idx)));
        chk(t == m_tag[idx], {req, " tag"}, 32'(t), 32'(m_tag[idx]));
        chk(d == m_eff_data(idx), {req, " data"}, 32'(d), 32'(m_eff_data(idx)));
    endtask

    // Drive one cycle, check both read ports, advance the reference model
    task automatic step(input bit iv, input int id, input int it, input bit mv, input int ms,
                        input int md, input bit bv, input int bt, input int bd,
                        input int ra, input int rb, input string req);
        logic          n_busy [NR];
        logic [TW-1:0] n_tag  [NR];
        logic [DW-1:0] n_val  [NR];
        bit            go, sb;
        @(negedge clk);
        iss_valid = iv; iss_dst = IW'(id); iss_tag = TW'(it);
        mv_valid = mv; mv_src = IW'(ms); mv_dst = IW'(md);
        bc_valid = bv; bc_tag = TW'(bt); bc_data = DW'(bd);
        rd_a_idx = IW'(ra); rd_b_idx = IW'(rb);
        #1;
        check_port(ra, rd_a_busy, rd_a_tag, rd_a_data, req);
        check_port(rb, rd_b_busy, rd_b_tag, rd_b_data, req);
        go = mv && !iv;
        sb = m_eff_busy(ms);
        for (int i = 0; i < NR; i++) begin
            n_busy[i] = m_busy[i]; n_tag[i] = m_tag[i]; n_val[i] = m_val[i];
            if (iv && id == i) begin
                n_busy[i] = 1'b1; n_tag[i] = TW'(it);
            end else if (go && md == i && sb) begin
                n_busy[i] = 1'b1; n_tag[i] = m_tag[ms];
            end else if (go && md == i) begin
                n_busy[i] = 1'b0; n_val[i] = m_eff_data(ms);
            end else if (m_hit(i)) begin
                n_busy[i] = 1'b0; n_val[i] = DW'(bd);
            end
        end
        for (int i = 0; i < NR; i++) begin
            m_busy[i] = n_busy[i]; m_tag[i] = n_tag[i]; m_val[i] = n_val[i];
        end
    endtask

    task automatic idle_read(input int ra, input int rb, input string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, ra, rb, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) begin
            m_busy[i] = 1'b0; m_tag[i] = '0; m_val[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset contents
        idle_read(0, 1, "R1");
        idle_read(2, 3, "R1");
        chk(rd_a_busy == 1'b0 && rd_a_data == '0, "R1 explicit", 32'(rd_a_data), 32'h0);

        // R4/R3 then R5/R2: issue r0, broadcast fills it
        step(1, 0, 3, 0, 0, 0, 0, 0, 0, 0, 1, "R2");
        idle_read(0, 0, "R3 R4");
        chk(rd_a_busy == 1'b1 && rd_a_tag == 4'd3, "R4 explicit", 32'(rd_a_tag), 32'd3);
        step(0, 0, 0, 0, 0, 0, 1, 3, 16'h1234, 1, 2, "R5");
        idle_read(0, 1, "R2 R5");
        chk(rd_a_data == 16'h1234 && !rd_a_busy, "R5 explicit", 32'(rd_a_data), 32'h1234);

        // R5 with two registers on one tag, R8 bypass in the broadcast cycle
        step(1, 1, 6, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 2, 6, 0, 0, 0, 0, 0, 0, 1, 1, "R3");
        step(0, 0, 0, 0, 0, 0, 1, 6, 16'hBEEF, 1, 2, "R8");
        chk(rd_b_busy == 1'b0 && rd_b_data == 16'hBEEF, "R8 explicit", 32'(rd_b_data), 32'hBEEF);
        idle_read(1, 2, "R5 multi");

        // R6: a stale broadcast after a retag
        step(1, 3, 7, 0, 0, 0, 0, 0, 0, 3, 3, "R4");
        step(1, 3, 8, 0, 0, 0, 0, 0, 0, 3, 3, "R4");
        step(0, 0, 0, 0, 0, 0, 1, 7, 16'h5555, 3, 0, "R6");
        idle_read(3, 0, "R6");
        chk(rd_a_busy == 1'b1 && rd_a_tag == 4'd8, "R6 explicit", 32'(rd_a_tag), 32'd8);
        step(0, 0, 0, 0, 0, 0, 1, 8, 16'h6666, 3, 3, "R5");

        // R7: issue collides with a matching broadcast
        step(1, 0, 9, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 0, 10, 0, 0, 0, 1, 9, 16'h4444, 0, 1, "R7");
        idle_read(0, 1, "R7");
        chk(rd_a_busy == 1'b1 && rd_a_tag == 4'd10 && rd_a_data == 16'h1234,
            "R7 explicit", 32'(rd_a_data), 32'h1234);

        // R9: move of a busy source, then one broadcast fills both
        step(0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 1, "R9");
        idle_read(1, 0, "R9");
        chk(rd_a_busy == 1'b1 && rd_a_tag == 4'd10, "R9 explicit", 32'(rd_a_tag), 32'd10);
        step(0, 0, 0, 0, 0, 0, 1, 10, 16'h7777, 0, 1, "R9");
        idle_read(0, 1, "R9");
        chk(rd_b_data == 16'h7777 && !rd_b_busy, "R9 fill", 32'(rd_b_data), 32'h7777);

        // R10: move from a ready source, and from a source bypassed this cycle
        step(0, 0, 0, 1, 2, 3, 0, 0, 0, 2, 3, "R10");
        idle_read(3, 2, "R10");
        chk(rd_a_data == 16'hBEEF && !rd_a_busy, "R10 explicit", 32'(rd_a_data), 32'hBEEF);
        step(1, 2, 11, 0, 0, 0, 0, 0, 0, 2, 2, "R4");
        step(0, 0, 0, 1, 2, 1, 1, 11, 16'h2222, 2, 1, "R10 bypass");
        idle_read(1, 2, "R10 bypass");
        chk(rd_a_data == 16'h2222 && !rd_a_busy, "R10 bypass explicit", 32'(rd_a_data), 32'h2222);

        // R11: issue and move in the same cycle
        step(1, 2, 12, 1, 0, 1, 0, 0, 0, 1, 2, "R11");
        idle_read(1, 2, "R11");
        chk(rd_a_busy == 1'b0 && rd_a_data == 16'h2222, "R11 explicit", 32'(rd_a_data), 32'h2222);

        // Random traffic checked against the model (R2 R3 R5 R6 R8 R9 R10 R11)
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 3) == 0, $urandom % NR, $urandom % 6,
                 ($urandom % 4) == 0, $urandom % NR, $urandom % NR,
                 ($urandom % 2) == 0, $urandom % 6, $urandom % 65536,
                 $urandom % NR, $urandom % NR, "random R2 R3 R5 R6 R8");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule